// File: doc/BRIEF.md
# Neighbour Shift Network for a Processing-Element Array

This block moves one byte from every processing element (PE) of a parallel array to an adjacent PE in a single operation. A flat input word holds one lane per PE. On a move strobe the block routes every lane to its neighbour and captures the result in a flat output word of the same width. The result is ready on the next cycle.

The same pair of words serves two layouts. In linear mode the PEs form a chain ordered by index. In grid mode the N = ROWS×COLS PEs are placed in row-major order and data moves one step up, down, left or right. Wrap-around is chosen on each move. With wrap-around on, edges connect to the opposite side. With it off, a destination with no source neighbour receives zero. A two-state controller sequences the capture. In ST_IDLE no result is pending. A move takes the controller from ST_IDLE to ST_VALID and loads the output. In ST_VALID a further move stays in ST_VALID, and a cycle without a move returns to ST_IDLE.

Top module: `pe_shift_net`

## Requirements
- R1: While reset is held and on the first cycle after it, dout_o is all zero and valid_o is low.
- R2: A move_i sampled high at a rising edge loads dout_o at that edge, and valid_o is high for the following cycle. valid_o is low in any cycle whose preceding edge saw move_i low.
- R3: When move_i is low at an edge, dout_o keeps its value whatever din_i, dir_i, mode_2d_i or wrap_i carry.
- R4: Linear mode (mode_2d_i=0) with dir_i[0]=0 (up): output lane j takes input lane j+1. dir_i[1] is ignored in linear mode.
- R5: Linear mode with dir_i[0]=1 (down): output lane j takes input lane j-1.
- R6: Linear edges. With wrap_i=1, an up move gives lane N-1 the input of lane 0, and a down move gives lane 0 the input of lane N-1. With wrap_i=0 the same edge lane becomes zero.
- R7: Grid mode (mode_2d_i=1), with dir_i=00 (up): output (r,c) takes input (r+1,c). With dir_i=01 (down): output (r,c) takes input (r-1,c).
- R8: Grid mode, with dir_i=10 (left): output (r,c) takes input (r,c+1). With dir_i=11 (right): output (r,c) takes input (r,c-1).
- R9: Grid edges. With wrap_i=1, row moves wrap within the column and column moves wrap within the row. With wrap_i=0, the edge row or column that has no source becomes zero.
- R10: Lane j occupies bits 8j to 8j+7 of din_i and dout_o (LANE_W=8). In grid mode lane j sits at row j/COLS and column j mod COLS.
- R11: The controller has two states, ST_IDLE and ST_VALID. A move enters or stays in ST_VALID, no move returns to ST_IDLE, and reset enters ST_IDLE. valid_o is high exactly in ST_VALID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| move_i | input | 1 | Move strobe; samples din_i and the controls |
| mode_2d_i | input | 1 | 0 = linear chain, 1 = grid |
| dir_i | input | 2 | 00 up, 01 down, 10 left, 11 right |
| wrap_i | input | 1 | 1 = edges wrap, 0 = edges fill with zero |
| din_i | input | LANE_W×ROWS×COLS | Flat input word, one lane per PE |
| dout_o | output | LANE_W×ROWS×COLS | Flat output word after the move |
| valid_o | output | 1 | High for the cycle after a move |

## Verification
The in-design assertions check the following on every cycle: the strobe-to-valid timing, that valid_o drops without a move, that the output holds between moves, and the linear up-shift edge lane in both wrap settings. Some properties can only be shown by the bench's scenarios, because they need a full reference comparison of every lane. These are the routing of interior lanes, grid moves in all four directions with both wrap settings, and the row-major placement on a non-square grid. The bench also checks that dir_i[1] is ignored in linear mode.

// File: rtl/pe_shift_pkg.sv
package pe_shift_pkg;

    typedef enum logic [1:0] {
        DIR_UP    = 2'b00,
        DIR_DOWN  = 2'b01,
        DIR_LEFT  = 2'b10,
        DIR_RIGHT = 2'b11
    } shift_dir_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } net_state_e;

endpackage

// File: rtl/pe_shift_route.sv
module pe_shift_route
    import pe_shift_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int LANE_W = 8
) (
    input  logic [LANE_W*ROWS*COLS-1:0] src_i,
    input  logic                        mode_2d_i,
    input  logic [1:0]                  dir_i,
    input  logic                        wrap_i,
    output logic [LANE_W*ROWS*COLS-1:0] dst_o
);
    localparam int N = ROWS * COLS;

    for (genvar j = 0; j < N; j++) begin : g_lane
        localparam int ROW = j / COLS;
        localparam int COL = j % COLS;
        // linear neighbours
        localparam int  UP1     = (j + 1) % N;
        localparam bit  UP1_EDG = (j == N - 1);
        localparam int  DN1     = (j + N - 1) % N;
        localparam bit  DN1_EDG = (j == 0);
        // grid neighbours, row-major placement
        localparam int  UP2     = ((ROW + 1) % ROWS) * COLS + COL;
        localparam bit  UP2_EDG = (ROW == ROWS - 1);
        localparam int  DN2     = ((ROW + ROWS - 1) % ROWS) * COLS + COL;
        localparam bit  DN2_EDG = (ROW == 0);
        localparam int  LF2     = ROW * COLS + (COL + 1) % COLS;
        localparam bit  LF2_EDG = (COL == COLS - 1);
        localparam int  RT2     = ROW * COLS + (COL + COLS - 1) % COLS;
        localparam bit  RT2_EDG = (COL == 0);

        logic [LANE_W-1:0] pick;
        logic              edge_hit;

        always_comb begin
            pick     = '0;
            edge_hit = 1'b0;
            if (!mode_2d_i) begin
                if (dir_i[0] == 1'b0) begin
                    pick     = src_i[UP1*LANE_W +: LANE_W];
                    edge_hit = UP1_EDG;
                end else begin
                    pick     = src_i[DN1*LANE_W +: LANE_W];
                    edge_hit = DN1_EDG;
                end
            end else begin
                unique case (dir_i)
                    DIR_UP: begin
                        pick     = src_i[UP2*LANE_W +: LANE_W];
                        edge_hit = UP2_EDG;
                    end
                    DIR_DOWN: begin
                        pick     = src_i[DN2*LANE_W +: LANE_W];
                        edge_hit = DN2_EDG;
                    end
                    DIR_LEFT: begin
                        pick     = src_i[LF2*LANE_W +: LANE_W];
                        edge_hit = LF2_EDG;
                    end
                    default: begin
                        pick     = src_i[RT2*LANE_W +: LANE_W];
                        edge_hit = RT2_EDG;
                    end
                endcase
            end
        end

        assign dst_o[j*LANE_W +: LANE_W] = (edge_hit && !wrap_i) ? '0 : pick;
    end

endmodule

// File: rtl/pe_shift_ctrl.sv
module pe_shift_ctrl
    import pe_shift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic move_i,
    output logic capture_o,
    output logic valid_o
);
    net_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (move_i)  state_d = ST_VALID;
            ST_VALID: if (!move_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o = move_i;
        valid_o   = (state_q == ST_VALID);
    end

    // R11
    state_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        move_i |=> (state_q == ST_VALID));

    // R11
    state_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !move_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/pe_shift_net.sv
module pe_shift_net
    import pe_shift_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int LANE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        move_i,
    input  logic                        mode_2d_i,
    input  logic [1:0]                  dir_i,
    input  logic                        wrap_i,
    input  logic [LANE_W*ROWS*COLS-1:0] din_i,
    output logic [LANE_W*ROWS*COLS-1:0] dout_o,
    output logic                        valid_o
);
    localparam int N    = ROWS * COLS;
    localparam int BITS = LANE_W * N;

    logic [BITS-1:0] routed;
    logic            capture;

    pe_shift_route #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .LANE_W (LANE_W)
    ) route_i (
        .src_i     (din_i),
        .mode_2d_i (mode_2d_i),
        .dir_i     (dir_i),
        .wrap_i    (wrap_i),
        .dst_o     (routed)
    );

    pe_shift_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .move_i    (move_i),
        .capture_o (capture),
        .valid_o   (valid_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       dout_o <= '0;
        else if (capture) dout_o <= routed;
    end

    // R2
    valid_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        move_i |=> valid_o);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !move_i |=> !valid_o);

    // R3
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !move_i |=> $stable(dout_o));

    // R6
    edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (move_i && !mode_2d_i && !dir_i[0] && !wrap_i)
        |=> (dout_o[(N-1)*LANE_W +: LANE_W] == '0));

    // R6
    edge_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (move_i && !mode_2d_i && !dir_i[0] && wrap_i)
        |=> (dout_o[(N-1)*LANE_W +: LANE_W] == $past(din_i[LANE_W-1:0])));

endmodule

// File: tb/pe_shift_net_tb_top.sv
module pe_shift_net_tb_top;
    localparam int ROWS = 3;
    localparam int COLS = 4;
    localparam int W    = 8;
    localparam int N    = ROWS * COLS;
    localparam int BW   = N * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          move_i, mode_2d_i, wrap_i;
    logic [1:0]    dir_i;
    logic [BW-1:0] din_i;
    logic [BW-1:0] dout_o;
    logic          valid_o;

    logic [BW-1:0] exp_dout;
    logic          exp_valid;
    int            checks = 0;
    int            fails  = 0;
    bit            done   = 1'b0;

    always #10 clk = ~clk;

    pe_shift_net #(.ROWS(ROWS), .COLS(COLS), .LANE_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .move_i(move_i), .mode_2d_i(mode_2d_i),
        .dir_i(dir_i), .wrap_i(wrap_i), .din_i(din_i),
        .dout_o(dout_o), .valid_o(valid_o)
    );

    // behavioural neighbour model: returns the source lane or -1 for none
    function automatic int src_of(int j, bit m2d, logic [1:0] d, bit wr);
        int r, c, s;
        r = j / COLS;
        c = j % COLS;
        s = -1;
        if (!m2d) begin
            if (!d[0]) s = (j + 1 < N) ? j + 1 : (wr ? 0 : -1);
            else       s = (j > 0) ? j - 1 : (wr ? N - 1 : -1);
        end else begin
            case (d)
                2'b00: s = (r + 1 < ROWS) ? (r + 1) * COLS + c : (wr ? c : -1);
                2'b01: s = (r > 0) ? (r - 1) * COLS + c : (wr ? (ROWS - 1) * COLS + c : -1);
                2'b10: s = (c + 1 < COLS) ? r * COLS + c + 1 : (wr ? r * COLS : -1);
                default: s = (c > 0) ? r * COLS + c - 1 : (wr ? r * COLS + COLS - 1 : -1);
            endcase
        end
        return s;
    endfunction

    function automatic logic [BW-1:0] model(logic [BW-1:0] d_in, bit m2d,
                                            logic [1:0] d, bit wr);
        logic [BW-1:0] res;
        res = '0;
        for (int j = 0; j < N; j++) begin
            int s;
            s = src_of(j, m2d, d, wr);
            if (s >= 0) res[j*W +: W] = d_in[s*W +: W];
        end
        return res;
    endfunction

    function automatic string tag_of(bit m2d, logic [1:0] d, bit wr);
        if (!m2d) return d[0] ? (wr ? "R5,R6" : "R5,R6") : (wr ? "R4,R6" : "R4,R6");
        return d[1] ? "R8,R9,R10" : "R7,R9,R10";
    endfunction

    task automatic compare(string req_d, string req_v);
        checks++;
        if (dout_o !== exp_dout) begin
            fails++;
            $display("FAIL %s dout actual=%h expected=%h", req_d, dout_o, exp_dout);
        end
        checks++;
        if (valid_o !== exp_valid) begin
            fails++;
            $display("FAIL %s valid actual=%b expected=%b", req_v, valid_o, exp_valid);
        end
    endtask

    // entered and left at a falling edge
    task automatic cycle(bit mv, bit m2d, logic [1:0] d, bit wr, logic [BW-1:0] data);
        string t;
        move_i = mv; mode_2d_i = m2d; dir_i = d; wrap_i = wr; din_i = data;
        @(posedge clk);
        if (mv) exp_dout = model(data, m2d, d, wr);
        exp_valid = mv;
        t = mv ? tag_of(m2d, d, wr) : "R3";
        @(negedge clk);
        compare(t, "R2,R11");
    endtask

    function automatic logic [BW-1:0] ramp(int base);
        logic [BW-1:0] v;
        for (int j = 0; j < N; j++) v[j*W +: W] = 8'(base + j + 1);
        return v;
    endfunction

    function automatic logic [BW-1:0] rnd();
        logic [BW-1:0] v;
        for (int j = 0; j < N; j++) v[j*W +: W] = 8'($urandom);
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; move_i = 1'b0; mode_2d_i = 1'b0; dir_i = 2'b00;
        wrap_i = 1'b0; din_i = '1;
        exp_dout = '0; exp_valid = 1'b0;
        repeat (3) @(negedge clk);
        compare("R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", "R1");

        // every mode, direction and wrap setting, with a hold cycle after each
        for (int m = 0; m < 2; m++)
            for (int d = 0; d < 4; d++)
                for (int w = 0; w < 2; w++) begin
                    cycle(1'b1, m[0], d[1:0], w[0], ramp(16 * d + 64 * m + 8 * w));
                    cycle(1'b0, ~m[0], ~d[1:0], ~w[0], rnd());
                end

        // R4 dir_i[1] ignored in linear mode: up via 10, down via 11
        cycle(1'b1, 1'b0, 2'b10, 1'b1, ramp(100));
        cycle(1'b1, 1'b0, 2'b11, 1'b0, ramp(150));

        // back-to-back moves keep valid high (R2, R11)
        cycle(1'b1, 1'b1, 2'b00, 1'b1, '1);
        cycle(1'b1, 1'b1, 2'b11, 1'b0, '1);
        cycle(1'b1, 1'b0, 2'b01, 1'b1, rnd());
        cycle(1'b0, 1'b0, 2'b00, 1'b0, '0);
        cycle(1'b0, 1'b1, 2'b10, 1'b1, rnd());

        // random traffic
        for (int i = 0; i < 200; i++) begin
            logic [1:0] rd;
            rd = 2'($urandom);
            cycle(1'($urandom), 1'($urandom), rd, 1'($urandom), rnd());
        end

        // reset in the middle clears the output (R1)
        cycle(1'b1, 1'b0, 2'b00, 1'b1, ramp(7));
        rst_n = 1'b0;
        move_i = 1'b0;
        @(negedge clk);
        exp_dout = '0; exp_valid = 1'b0;
        compare("R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule